// File: doc/BRIEF.md
# Unified Out-of-Order Instruction Window Scheduler

This block is a single out-of-order instruction window. It does the work of the reservation stations and of the reorder buffer in one circular queue of slots. Decoded instructions arrive one per cycle and are written into the slot at the tail. The index of that slot is the instruction's tag. Each source operand is read from one of three places: the architectural register file, a completed but uncommitted slot, or the result bus in that same cycle. If none of these has the value, the operand waits for its producer's tag to appear on the result bus. No slot is tied to a functional-unit class. The class is chosen at dispatch, where every free unit gets the oldest operand-ready slot of its class.

Functional units report their results on per-unit completion lanes. A fixed-priority arbiter lets exactly one of them onto the single result bus each cycle. The lanes that lose keep their results and try again later. The slot at the head retires in order once its result has arrived. Retiring writes the architectural register and, if the rename entry of that register still names the retiring slot, clears it. The slot then becomes free.

Top module: `ruu_sched`

## Requirements
- R1: The tag of an instruction is the index of the slot it occupies. Slots are assigned in issue order from index 0 upward and wrap modulo DEPTH (a power of two). Two lanes never receive the same tag in one cycle.
- R2: `iss_ready` is low exactly while DEPTH slots are occupied. A slot is released only by a commit, so `iss_ready` can rise only in a cycle that shows `cmt_valid`.
- R3: Commits appear on `cmt_valid`/`cmt_dst`/`cmt_data` in issue order, at most one per cycle. The value matches sequential execution of the issued instructions, where class 0 computes a+b+1 and class 1 computes (a xor b)+3 modulo 2^DW on the operands that the functional units return.
- R4: `dsp_valid[c]` is raised (registered) only in the cycle after a cycle in which `fu_free[c]` was high. Lane c receives only slots whose class field equals c.
- R5: If several slots of one class are operand-ready, that class's lane receives the one closest to the head.
- R6: In any cycle at most one bit of `cmp_ack` is high, and it is the lowest-numbered lane with `cmp_valid` set. An acknowledged lane's value is on the result bus in that cycle.
- R7: A waiting operand captures the result-bus value whose tag matches it. This includes a bus value that appears in the same cycle as the consumer is issued, so no wakeup is lost.
- R8: A register whose rename entry is cleared by commit is read from the architectural register file. A later writer's rename entry is never cleared by an earlier writer's commit.
- R9: After reset the window is empty: `iss_ready`=1, `dsp_valid`=0, `cmt_valid`=0, `cmp_ack`=0, and all architectural registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Decoded instruction offered |
| iss_ready | output | 1 | A free slot exists; the offer is taken at the edge |
| iss_class | input | CW | Functional-unit class of the instruction |
| iss_dst | input | RW | Destination register |
| iss_src1 | input | RW | First source register |
| iss_src2 | input | RW | Second source register |
| fu_free | input | NCLASS | Unit of each class can accept an instruction |
| dsp_valid | output | NCLASS | Instruction sent to the unit of each class |
| dsp_tag | output | NCLASS x TW | Tag of the dispatched instruction |
| dsp_a | output | NCLASS x DW | First operand value |
| dsp_b | output | NCLASS x DW | Second operand value |
| cmp_valid | input | NCLASS | Unit holds a finished result |
| cmp_tag | input | NCLASS x TW | Tag of the finished result |
| cmp_data | input | NCLASS x DW | Finished result value |
| cmp_ack | output | NCLASS | Lane granted the result bus this cycle |
| cmt_valid | output | 1 | An instruction retired at the last edge |
| cmt_dst | output | RW | Register written by the retirement |
| cmt_data | output | DW | Value written by the retirement |

## Verification
The properties assume that each functional unit behaves in order. A unit accepts a dispatch only while it reports free. It later raises `cmp_valid` with the tag it was given and holds the lane steady until `cmp_ack`. It never reports a tag that is not in flight. The bench models each unit as one busy slot with a fixed latency (one cycle for class 0, three for class 1). It lowers `fu_free` whenever the unit is busy, and at random other times, and it never drops a result before it is acknowledged. Instruction fields come from `$urandom` under a fixed seed, and `iss_valid` is raised only while `iss_ready` is high.

// File: rtl/ruu_pkg.sv
package ruu_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_DISP = 2'd1,
    ST_DONE = 2'd2
  } slot_state_e;
endpackage

// File: rtl/ruu_result_arb.sv
module ruu_result_arb #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any,
  output logic [(N>1 ? $clog2(N) : 1)-1:0] idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  always_comb begin
    gnt = '0;
    any = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        any = 1'b1;
        idx = IW'(k);
      end
    end
    if (any) gnt[idx] = 1'b1;
  end
endmodule

// File: rtl/ruu_pick_oldest.sv
module ruu_pick_oldest #(
  parameter int DEPTH = 8,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  input  logic [TW-1:0]    head,
  output logic             found,
  output logic [TW-1:0]    idx
);
  logic [TW-1:0] pos;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    pos   = '0;
    // scan youngest to oldest so the slot nearest the head wins
    for (int k = DEPTH - 1; k >= 0; k--) begin
      pos = head + TW'(k);
      if (req[pos]) begin
        found = 1'b1;
        idx   = pos;
      end
    end
  end
endmodule

// File: rtl/ruu_sched.sv
module ruu_sched
  import ruu_pkg::*;
#(
  parameter int DEPTH  = 8,   // power of two
  parameter int NREG   = 8,
  parameter int DW     = 16,
  parameter int NCLASS = 2,
  localparam int TW = $clog2(DEPTH),
  localparam int RW = $clog2(NREG),
  localparam int CW = (NCLASS > 1) ? $clog2(NCLASS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         iss_valid,
  output logic                         iss_ready,
  input  logic [CW-1:0]                iss_class,
  input  logic [RW-1:0]                iss_dst,
  input  logic [RW-1:0]                iss_src1,
  input  logic [RW-1:0]                iss_src2,
  input  logic [NCLASS-1:0]            fu_free,
  output logic [NCLASS-1:0]            dsp_valid,
  output logic [NCLASS-1:0][TW-1:0]    dsp_tag,
  output logic [NCLASS-1:0][DW-1:0]    dsp_a,
  output logic [NCLASS-1:0][DW-1:0]    dsp_b,
  input  logic [NCLASS-1:0]            cmp_valid,
  input  logic [NCLASS-1:0][TW-1:0]    cmp_tag,
  input  logic [NCLASS-1:0][DW-1:0]    cmp_data,
  output logic [NCLASS-1:0]            cmp_ack,
  output logic                         cmt_valid,
  output logic [RW-1:0]                cmt_dst,
  output logic [DW-1:0]                cmt_data
);
  localparam int IW = (NCLASS > 1) ? $clog2(NCLASS) : 1;

  // slot storage
  logic [DEPTH-1:0] e_valid;
  slot_state_e      e_st  [DEPTH];
  logic [CW-1:0]    e_cls [DEPTH];
  logic [RW-1:0]    e_dst [DEPTH];
  logic             e_r1  [DEPTH];
  logic             e_r2  [DEPTH];
  logic [TW-1:0]    e_q1  [DEPTH];
  logic [TW-1:0]    e_q2  [DEPTH];
  logic [DW-1:0]    e_v1  [DEPTH];
  logic [DW-1:0]    e_v2  [DEPTH];
  logic [DW-1:0]    e_res [DEPTH];

  logic [TW-1:0] head, tail;
  logic [TW:0]   count;

  // architectural state and rename table
  logic [DW-1:0] arf   [NREG];
  logic          ren_v [NREG];
  logic [TW-1:0] ren_t [NREG];

  // result bus
  logic          bus_v;
  logic [IW-1:0] bus_sel;
  logic [TW-1:0] bus_tag;
  logic [DW-1:0] bus_data;

  ruu_result_arb #(.N(NCLASS)) u_arb (
    .req (cmp_valid),
    .gnt (cmp_ack),
    .any (bus_v),
    .idx (bus_sel)
  );
  assign bus_tag  = cmp_tag[bus_sel];
  assign bus_data = cmp_data[bus_sel];

  // issue-side operand read with same-cycle bus bypass
  logic          iss_fire, do_commit;
  logic [RW-1:0] rd_reg [2];
  logic [TW-1:0] rd_tag [2];
  logic [DW-1:0] rd_val [2];
  logic          rd_rdy [2];

  assign iss_ready = (count != (TW+1)'(DEPTH));
  assign iss_fire  = iss_valid && iss_ready;
  assign do_commit = e_valid[head] && (e_st[head] == ST_DONE);
  assign rd_reg[0] = iss_src1;
  assign rd_reg[1] = iss_src2;

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      rd_tag[s] = ren_t[rd_reg[s]];
      rd_val[s] = arf[rd_reg[s]];
      rd_rdy[s] = 1'b1;
      if (ren_v[rd_reg[s]]) begin
        if (e_st[rd_tag[s]] == ST_DONE)
          rd_val[s] = e_res[rd_tag[s]];
        else if (bus_v && bus_tag == rd_tag[s])
          rd_val[s] = bus_data;
        else
          rd_rdy[s] = 1'b0;
      end
    end
  end

  // per-class oldest-ready selection
  logic [NCLASS-1:0]         pk_v;
  logic [NCLASS-1:0][TW-1:0] pk_i;

  for (genvar c = 0; c < NCLASS; c++) begin : g_cls
    logic [DEPTH-1:0] req;
    always_comb begin
      for (int i = 0; i < DEPTH; i++)
        req[i] = e_valid[i] && (e_st[i] == ST_WAIT) && e_r1[i] && e_r2[i]
                 && (e_cls[i] == CW'(c)) && fu_free[c];
    end
    ruu_pick_oldest #(.DEPTH(DEPTH)) u_pick (
      .req   (req),
      .head  (head),
      .found (pk_v[c]),
      .idx   (pk_i[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      e_valid   <= '0;
      dsp_valid <= '0;
      cmt_valid <= 1'b0;
      cmt_dst   <= '0;
      cmt_data  <= '0;
      for (int r = 0; r < NREG; r++) begin
        arf[r]   <= '0;
        ren_v[r] <= 1'b0;
        ren_t[r] <= '0;
      end
    end else begin
      // result bus: finish producer, wake consumers
      if (bus_v) begin
        e_st[bus_tag]  <= ST_DONE;
        e_res[bus_tag] <= bus_data;
        for (int i = 0; i < DEPTH; i++) begin
          if (e_valid[i] && e_st[i] == ST_WAIT) begin
            if (!e_r1[i] && e_q1[i] == bus_tag) begin
              e_r1[i] <= 1'b1;
              e_v1[i] <= bus_data;
            end
            if (!e_r2[i] && e_q2[i] == bus_tag) begin
              e_r2[i] <= 1'b1;
              e_v2[i] <= bus_data;
            end
          end
        end
      end
      // dispatch
      for (int c = 0; c < NCLASS; c++) begin
        dsp_valid[c] <= pk_v[c];
        if (pk_v[c]) begin
          e_st[pk_i[c]] <= ST_DISP;
          dsp_tag[c]    <= pk_i[c];
          dsp_a[c]      <= e_v1[pk_i[c]];
          dsp_b[c]      <= e_v2[pk_i[c]];
        end
      end
      // in-order commit
      cmt_valid <= do_commit;
      if (do_commit) begin
        arf[e_dst[head]] <= e_res[head];
        if (ren_v[e_dst[head]] && ren_t[e_dst[head]] == head)
          ren_v[e_dst[head]] <= 1'b0;
        e_valid[head] <= 1'b0;
        head          <= head + 1'b1;
        cmt_dst       <= e_dst[head];
        cmt_data      <= e_res[head];
      end
      // issue into tail (later write wins over the commit clear)
      if (iss_fire) begin
        e_valid[tail] <= 1'b1;
        e_st[tail]    <= ST_WAIT;
        e_cls[tail]   <= iss_class;
        e_dst[tail]   <= iss_dst;
        e_r1[tail]    <= rd_rdy[0];
        e_r2[tail]    <= rd_rdy[1];
        e_q1[tail]    <= rd_tag[0];
        e_q2[tail]    <= rd_tag[1];
        e_v1[tail]    <= rd_val[0];
        e_v2[tail]    <= rd_val[1];
        ren_v[iss_dst] <= 1'b1;
        ren_t[iss_dst] <= tail;
        tail           <= tail + 1'b1;
      end
      case ({iss_fire, do_commit})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ruu_sched_chk.sv
module ruu_sched_chk #(
  parameter int NCLASS = 2,
  parameter int TW     = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      iss_ready,
  input logic [NCLASS-1:0]         fu_free,
  input logic [NCLASS-1:0]         dsp_valid,
  input logic [NCLASS-1:0][TW-1:0] dsp_tag,
  input logic [NCLASS-1:0]         cmp_valid,
  input logic [NCLASS-1:0]         cmp_ack,
  input logic                      cmt_valid
);
  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dsp_valid == '0 && !cmt_valid));

  // R6
  bus_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmp_ack));

  // R6
  ack_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_ack & ~cmp_valid) == '0);

  // R4
  dispatch_free_chk: assert property (@(posedge clk) disable iff (rst)
    (dsp_valid & ~$past(fu_free)) == '0);

  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(iss_ready) |-> cmt_valid);

  if (NCLASS > 1) begin : g_pair
    // R1
    tag_unique_chk: assert property (@(posedge clk) disable iff (rst)
      (dsp_valid[0] && dsp_valid[1]) |-> (dsp_tag[0] != dsp_tag[1]));
  end
endmodule

bind ruu_sched ruu_sched_chk #(.NCLASS(NCLASS), .TW($clog2(DEPTH))) u_chk (
  .clk       (clk),
  .rst       (rst),
  .iss_ready (iss_ready),
  .fu_free   (fu_free),
  .dsp_valid (dsp_valid),
  .dsp_tag   (dsp_tag),
  .cmp_valid (cmp_valid),
  .cmp_ack   (cmp_ack),
  .cmt_valid (cmt_valid)
);

// File: tb/ruu_sched_bench.sv
`timescale 1ns/1ps
module ruu_sched_bench;
  localparam int DEPTH = 8, NREG = 8, DW = 16, NCLASS = 2;
  localparam int TW = $clog2(DEPTH), RW = $clog2(NREG), CW = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 1'b0, iss_ready;
  logic [CW-1:0] iss_class = '0;
  logic [RW-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic [NCLASS-1:0] fu_free = '0, dsp_valid, cmp_valid = '0, cmp_ack;
  logic [NCLASS-1:0][TW-1:0] dsp_tag, cmp_tag = '0;
  logic [NCLASS-1:0][DW-1:0] dsp_a, dsp_b, cmp_data = '0;
  logic cmt_valid;
  logic [RW-1:0] cmt_dst;
  logic [DW-1:0] cmt_data;

  always #4 clk = ~clk;

  ruu_sched #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW), .NCLASS(NCLASS)) u_ruu_sched (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_class(iss_class), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .fu_free(fu_free), .dsp_valid(dsp_valid), .dsp_tag(dsp_tag), .dsp_a(dsp_a),
    .dsp_b(dsp_b), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
    .cmp_ack(cmp_ack), .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_data(cmt_data)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] ref_rf [NREG];
  logic [RW-1:0] exp_dst [4096];
  logic [DW-1:0] exp_val [4096];
  int wr_ptr = 0, rd_ptr = 0;
  logic fu_busy [NCLASS];
  int   fu_tmr  [NCLASS];
  logic [TW-1:0] fu_tag [NCLASS];
  logic [DW-1:0] fu_res [NCLASS];
  bit hold_fu = 1'b0, throttle = 1'b0, order_chk = 1'b0;
  int exp_order = 0;
  logic [CW-1:0] d_cls;
  logic [RW-1:0] d_dst, d_s1, d_s2;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] fu_op(input int c, input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    return (c == 0) ? DW'(a + b + 1) : DW'((a ^ b) + 3);
  endfunction

  // one cycle: observe outputs at the negedge, then drive inputs
  task automatic step(input bit want, input bit use_rand);
    logic [NCLASS-1:0] exp_ack;
    logic [DW-1:0] r;
    @(negedge clk);
    if (cmt_valid) begin
      if (rd_ptr >= wr_ptr) chk(1'b0, "R3", "commit with nothing issued", rd_ptr, wr_ptr);
      else begin
        chk(cmt_dst == exp_dst[rd_ptr], "R3", "commit dst", int'(cmt_dst), int'(exp_dst[rd_ptr]));
        // R7 R8: values depend on wakeup, bypass and rename
        chk(cmt_data == exp_val[rd_ptr], "R7", "commit data", int'(cmt_data), int'(exp_val[rd_ptr]));
        rd_ptr++;
      end
    end
    exp_ack = cmp_valid & (~cmp_valid + 1'b1);
    if (cmp_valid != '0)
      chk(cmp_ack == exp_ack, "R6", "bus grant", int'(cmp_ack), int'(exp_ack));
    for (int c = 0; c < NCLASS; c++)
      if (cmp_valid[c] && cmp_ack[c]) begin
        fu_busy[c] = 1'b0;
        cmp_valid[c] = 1'b0;
      end
    for (int c = 0; c < NCLASS; c++)
      if (dsp_valid[c]) begin
        if (fu_busy[c]) chk(1'b0, "R4", "dispatch to busy unit", c, -1);
        if (order_chk && c == 0) begin
          chk(int'(dsp_tag[0]) == exp_order % DEPTH, "R5", "oldest-first tag",
              int'(dsp_tag[0]), exp_order % DEPTH);
          exp_order++;
        end
        fu_busy[c] = 1'b1;
        fu_tag[c]  = dsp_tag[c];
        fu_res[c]  = fu_op(c, dsp_a[c], dsp_b[c]);
        fu_tmr[c]  = (c == 0) ? 1 : 3;
      end
    for (int c = 0; c < NCLASS; c++)
      if (fu_busy[c] && !cmp_valid[c]) begin
        if (fu_tmr[c] <= 1) begin
          cmp_valid[c] = 1'b1;
          cmp_tag[c]   = fu_tag[c];
          cmp_data[c]  = fu_res[c];
        end else fu_tmr[c]--;
      end
    for (int c = 0; c < NCLASS; c++)
      fu_free[c] = !fu_busy[c] && !hold_fu && !(throttle && ($urandom % 4 == 0));
    if (want && iss_ready) begin
      if (use_rand) begin
        iss_class = CW'($urandom % NCLASS);
        iss_dst   = RW'($urandom % NREG);
        iss_src1  = RW'($urandom % NREG);
        iss_src2  = RW'($urandom % NREG);
      end else begin
        iss_class = d_cls; iss_dst = d_dst; iss_src1 = d_s1; iss_src2 = d_s2;
      end
      iss_valid = 1'b1;
      r = fu_op(int'(iss_class), ref_rf[iss_src1], ref_rf[iss_src2]);
      ref_rf[iss_dst] = r;
      exp_dst[wr_ptr] = iss_dst;
      exp_val[wr_ptr] = r;
      wr_ptr++;
    end else iss_valid = 1'b0;
  endtask

  task automatic drain();
    for (int n = 0; n < 400 && rd_ptr < wr_ptr; n++) step(1'b0, 1'b0);
    chk(rd_ptr == wr_ptr, "R3", "all issued committed", rd_ptr, wr_ptr);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired R3 actual=%0d expected=%0d", rd_ptr, wr_ptr);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < NREG; r++) ref_rf[r] = '0;
    for (int c = 0; c < NCLASS; c++) begin
      fu_busy[c] = 1'b0; fu_tmr[c] = 0; fu_tag[c] = '0; fu_res[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(iss_ready == 1'b1, "R9", "ready after reset", int'(iss_ready), 1);
    chk(dsp_valid == '0, "R9", "no dispatch after reset", int'(dsp_valid), 0);
    chk(cmt_valid == 1'b0, "R9", "no commit after reset", int'(cmt_valid), 0);
    chk(cmp_ack == '0, "R9", "no ack after reset", int'(cmp_ack), 0);

    // R2 fill the window with units held busy
    hold_fu = 1'b1;
    d_cls = 1'b0; d_dst = RW'(7); d_s1 = RW'(0); d_s2 = RW'(1);
    for (int k = 0; k < DEPTH; k++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk(wr_ptr == DEPTH, "R2", "slots accepted", wr_ptr, DEPTH);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0);
      chk(iss_ready == 1'b0, "R2", "full stalls issue", int'(iss_ready), 0);
      chk(cmt_valid == 1'b0, "R2", "no release without commit", int'(cmt_valid), 0);
      chk(dsp_valid == '0, "R4", "no dispatch while units held", int'(dsp_valid), 0);
    end
    // R5 R1 release: slots must leave oldest first, tags 0..DEPTH-1
    hold_fu = 1'b0; order_chk = 1'b1; exp_order = 0;
    drain();
    order_chk = 1'b0;
    chk(exp_order == DEPTH, "R5", "dispatch count", exp_order, DEPTH);
    step(1'b0, 1'b0);
    chk(iss_ready == 1'b1, "R2", "ready after drain", int'(iss_ready), 1);

    // R7 R8 dependent chain across both classes
    for (int k = 0; k < 6; k++) begin
      d_cls = CW'(k % 2); d_dst = RW'(2); d_s1 = RW'(2); d_s2 = RW'(3);
      step(1'b1, 1'b0);
    end
    drain();

    // R1 R3 R4 R6 random mix with unit throttling
    throttle = 1'b1;
    for (int k = 0; k < 3000; k++) step(($urandom % 100) < 70, 1'b1);
    throttle = 1'b0;
    drain();
    step(1'b0, 1'b0);
    chk(iss_ready == 1'b1, "R2", "empty at end", int'(iss_ready), 1);
    chk(wr_ptr > 1000, "R1", "enough traffic", wr_ptr, 1000);
    summary();
  end
endmodule